// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Flags

This block is the arithmetic core of an 8-bit accumulator datapath. It keeps an accumulator register and a six-bit status register. On every clock edge where the load strobe is high, it applies one operation to them. The operation comes from a decoded 3-bit select, and some operations also use an 8-bit immediate operand. The supported operations are two's-complement negation, carry complement, carry set, decimal (BCD) correction, immediate addition, and immediate addition with carry in.

The surrounding sequencer decodes instructions and drives the select, operand and strobe. The block reports the accumulator and the flags continuously on its outputs. A single shared adder serves negation and both additions. A separate correction unit handles decimal adjust, and a parameter can leave that unit out.

Top module: `acc_alu`

## Requirements
- R1: An active-low asynchronous reset clears the accumulator and all six flags to zero. The flag output is laid out as bit 5 sign (S), bit 4 zero (Z), bit 3 half-carry (H), bit 2 parity/overflow (PV), bit 1 subtract (N) and bit 0 carry (C).
- R2: The select encoding is 0 negate, 1 complement carry, 2 set carry, 3 decimal adjust, 4 add immediate, 5 add immediate with carry. With the strobe low, or with select 6 or 7, the accumulator and flags keep their values.
- R3: Negate loads 0 minus the accumulator (mod 256). S copies result bit 7 and Z is set for a zero result. H is set when the old low nibble was nonzero, which is a borrow into bit 4. N is set.
- R4: Negate sets PV only if the old accumulator was 0x80, and sets C only if the old accumulator was not 0x00.
- R5: Complement carry inverts C, copies the old C into H and clears N. The accumulator, S, Z and PV are unchanged.
- R6: Set carry forces C to 1 and clears H and N. The accumulator, S, Z and PV are unchanged.
- R7: Add immediate loads accumulator plus operand (mod 256). H is the carry out of bit 3 and C is the carry out of bit 7. PV is set on signed overflow. N is cleared, and S and Z follow the result.
- R8: Add immediate with carry adds the operand and the current C to the accumulator, with the same flag rules as R7.
- R9: Decimal adjust with N clear adds 0x06 if the low nibble exceeds 9 or H is set. It adds 0x60 if the accumulator exceeds 0x99 or C is set. H becomes 1 when the low nibble exceeds 9.
- R10: Decimal adjust with N set subtracts the same corrections instead. H becomes 1 when the nibble correction applies and the low nibble is below 6.
- R11: After decimal adjust, C is 1 exactly when the 0x60 correction applied. S copies bit 7, Z marks a zero result, PV is 1 for an even count of one bits in the result, and N keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_i | input | 1 | Load strobe; the operation takes effect on this edge |
| op_i | input | 3 | Decoded operation select |
| imm_i | input | 8 | Immediate operand |
| acc_o | output | 8 | Accumulator value |
| flags_o | output | 6 | Status flags {S,Z,H,PV,N,C} |

## Verification
The bench builds the block with its defaults: an 8-bit data width and the decimal-adjust unit present. With these settings every accumulator value can be set up through immediate additions, and each operation is applied from all 256 starting values with carry both clear and set. Decimal adjust is reached once with the subtract flag clear (after an addition) and once with it set (after a negation). This exercises both correction directions and the nibble and byte borrow boundaries.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [2:0] {
      OP_NEG  = 3'd0,
      OP_CCF  = 3'd1,
      OP_SCF  = 3'd2,
      OP_DAA  = 3'd3,
      OP_ADDI = 3'd4,
      OP_ADCI = 3'd5,
      OP_NOP6 = 3'd6,
      OP_NOP7 = 3'd7
   } alu_op_e;

   typedef struct packed {
      logic s;
      logic z;
      logic h;
      logic pv;
      logic n;
      logic c;
   } alu_flags_t;

   localparam int unsigned FLAG_W = $bits(alu_flags_t);

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
   parameter int unsigned W   = 8,
   parameter int unsigned NIB = 4
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         c_nib_o,
   output logic         c_top_o,
   output logic         ovf_o
);
   logic [NIB:0] low_sum;
   logic [W:0]   full_sum;

   always_comb begin
      low_sum  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
      full_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
   end

   assign sum_o   = full_sum[W-1:0];
   assign c_nib_o = low_sum[NIB];
   assign c_top_o = full_sum[W];
   assign ovf_o   = (a_i[W-1] == b_i[W-1]) && (full_sum[W-1] != a_i[W-1]);

endmodule

// File: rtl/acc_alu_daa.sv
module acc_alu_daa #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic         h_i,
   input  logic         n_i,
   input  logic         c_i,
   output logic [W-1:0] res_o,
   output logic         h_o,
   output logic         c_o
);
   localparam logic [W-1:0] LO_FIX  = W'(8'h06);
   localparam logic [W-1:0] HI_FIX  = W'(8'h60);
   localparam logic [W-1:0] HI_LIM  = W'(8'h99);

   logic         lo_big, lo_need, hi_need;
   logic [W-1:0] corr;

   always_comb begin
      lo_big  = a_i[3:0] > 4'd9;
      lo_need = lo_big || h_i;
      hi_need = (a_i > HI_LIM) || c_i;
      corr    = (lo_need ? LO_FIX : '0) | (hi_need ? HI_FIX : '0);
      res_o   = n_i ? (a_i - corr) : (a_i + corr);
      h_o     = n_i ? (lo_need && (a_i[3:0] < 4'd6)) : lo_big;
      c_o     = hi_need;
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter bit          HAS_DAA = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ld_i,
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] imm_i,
   output logic [DATA_W-1:0] acc_o,
   output logic [FLAG_W-1:0] flags_o
);
   localparam int unsigned NIB_W = 4;

   if (DATA_W != 8) begin : g_bad_width
      $error("acc_alu: DATA_W must be 8 for nibble and decimal semantics");
   end

   logic [DATA_W-1:0] acc_q, acc_d;
   alu_flags_t        flg_q, flg_d;
   alu_op_e           op;

   logic [DATA_W-1:0] add_a, add_b, add_sum;
   logic              add_cin, add_c3, add_c7, add_ov;
   logic [DATA_W-1:0] daa_res;
   logic              daa_h, daa_c;

   assign op = alu_op_e'(op_i);

   // shared adder: negate is 0 + ~acc + 1
   always_comb begin
      add_a   = (op == OP_NEG) ? '0 : acc_q;
      add_b   = (op == OP_NEG) ? ~acc_q : imm_i;
      add_cin = (op == OP_NEG) || ((op == OP_ADCI) && flg_q.c);
   end

   acc_alu_adder #(.W(DATA_W), .NIB(NIB_W)) u_add (
      .a_i    (add_a),
      .b_i    (add_b),
      .cin_i  (add_cin),
      .sum_o  (add_sum),
      .c_nib_o(add_c3),
      .c_top_o(add_c7),
      .ovf_o  (add_ov)
   );

   if (HAS_DAA) begin : g_daa
      acc_alu_daa #(.W(DATA_W)) u_daa (
         .a_i  (acc_q),
         .h_i  (flg_q.h),
         .n_i  (flg_q.n),
         .c_i  (flg_q.c),
         .res_o(daa_res),
         .h_o  (daa_h),
         .c_o  (daa_c)
      );
   end else begin : g_no_daa
      assign daa_res = acc_q;
      assign daa_h   = flg_q.h;
      assign daa_c   = flg_q.c;
   end

   always_comb begin
      acc_d = acc_q;
      flg_d = flg_q;
      case (op)
         OP_NEG: begin
            acc_d    = add_sum;
            flg_d.s  = add_sum[DATA_W-1];
            flg_d.z  = (add_sum == '0);
            flg_d.h  = ~add_c3;
            flg_d.pv = add_ov;
            flg_d.n  = 1'b1;
            flg_d.c  = ~add_c7;
         end
         OP_CCF: begin
            flg_d.h = flg_q.c;
            flg_d.c = ~flg_q.c;
            flg_d.n = 1'b0;
         end
         OP_SCF: begin
            flg_d.h = 1'b0;
            flg_d.c = 1'b1;
            flg_d.n = 1'b0;
         end
         OP_DAA: begin
            if (HAS_DAA) begin
               acc_d    = daa_res;
               flg_d.s  = daa_res[DATA_W-1];
               flg_d.z  = (daa_res == '0);
               flg_d.h  = daa_h;
               flg_d.pv = ~^daa_res;
               flg_d.c  = daa_c;
            end
         end
         OP_ADDI, OP_ADCI: begin
            acc_d    = add_sum;
            flg_d.s  = add_sum[DATA_W-1];
            flg_d.z  = (add_sum == '0);
            flg_d.h  = add_c3;
            flg_d.pv = add_ov;
            flg_d.n  = 1'b0;
            flg_d.c  = add_c7;
         end
         default: begin
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q <= '0;
         flg_q <= '0;
      end else if (ld_i) begin
         acc_q <= acc_d;
         flg_q <= flg_d;
      end
   end

   assign acc_o   = acc_q;
   assign flags_o = flg_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
   import acc_alu_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       ld,
   input logic [2:0] op,
   input logic [7:0] imm,
   input logic [7:0] acc,
   input logic [5:0] flags
);
   // flag bit positions: 5 S, 4 Z, 3 H, 2 PV, 1 N, 0 C

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld || op == OP_NOP6 || op == OP_NOP7) |=> ($stable(acc) && $stable(flags)));

   p_neg_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && op == OP_NEG) |=> (flags[2] == ($past(acc) == 8'h80)) &&
                               (flags[0] == ($past(acc) != 8'h00)) && flags[1]);

   p_ccf_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && op == OP_CCF) |=> (flags[0] == !$past(flags[0])) &&
                               (flags[3] == $past(flags[0])) && !flags[1] &&
                               $stable(acc) && (flags[5:4] == $past(flags[5:4])) &&
                               (flags[2] == $past(flags[2])));

   p_scf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && op == OP_SCF) |=> flags[0] && !flags[3] && !flags[1] && $stable(acc));

   p_add_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && op == OP_ADDI) |=> (acc == 8'($past(acc) + $past(imm))) && !flags[1]);

   p_adc_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && op == OP_ADCI) |=>
         (acc == 8'($past(acc) + $past(imm) + {7'd0, $past(flags[0])})));

   p_daa_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && op == OP_DAA) |=> (flags[2] == ~^acc) && (flags[4] == (acc == 8'h00)) &&
                               (flags[5] == acc[7]) && (flags[1] == $past(flags[1])));

   p_zero_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && (op == OP_NEG || op == OP_ADDI || op == OP_ADCI)) |=>
         (flags[4] == (acc == 8'h00)) && (flags[5] == acc[7]));

endmodule

bind acc_alu acc_alu_chk u_chk (
   .clk  (clk_i),
   .rst_n(rst_ni),
   .ld   (ld_i),
   .op   (op_i),
   .imm  (imm_i),
   .acc  (acc_o),
   .flags(flags_o)
);

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ld = 1'b0;
   logic [2:0] op = 3'd0;
   logic [7:0] imm = 8'd0;
   logic [7:0] acc_o;
   logic [5:0] flags_o;

   int checks = 0;
   int errors = 0;

   // reference state
   int   m_acc = 0;
   logic ms = 0, mz = 0, mh = 0, mpv = 0, mn = 0, mc = 0;

   always #4 clk = ~clk;

   acc_alu dut (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .ld_i   (ld),
      .op_i   (op),
      .imm_i  (imm),
      .acc_o  (acc_o),
      .flags_o(flags_o)
   );

   function automatic int sgn(input int v);
      return (v >= 128) ? v - 256 : v;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_acc = 0; ms = 0; mz = 0; mh = 0; mpv = 0; mn = 0; mc = 0;
      end else if (ld) begin
         int a, b, r, cin, ss, corr, ones;
         logic lo, hi;
         a = m_acc; b = int'(imm);
         case (op)
            3'd0: begin
               r = (256 - a) % 256;
               mh = (a % 16) != 0; mpv = (a == 128); mc = (a != 0); mn = 1;
               m_acc = r; ms = r >= 128; mz = r == 0;
            end
            3'd1: begin mh = mc; mc = !mc; mn = 0; end
            3'd2: begin mh = 0; mc = 1; mn = 0; end
            3'd3: begin
               lo = ((a % 16) > 9) || mh;
               hi = (a > 153) || mc;
               corr = (lo ? 6 : 0) + (hi ? 96 : 0);
               r = mn ? ((a - corr + 256) % 256) : ((a + corr) % 256);
               mh = mn ? (lo && ((a % 16) < 6)) : ((a % 16) > 9);
               mc = hi;
               ones = 0;
               for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
               mpv = (ones % 2) == 0;
               m_acc = r; ms = r >= 128; mz = r == 0;
            end
            3'd4, 3'd5: begin
               cin = (op == 3'd5 && mc) ? 1 : 0;
               r = a + b + cin;
               mh = ((a % 16) + (b % 16) + cin) > 15;
               mc = r > 255;
               ss = sgn(a) + sgn(b) + cin;
               mpv = (ss > 127) || (ss < -128);
               mn = 0;
               r = r % 256;
               m_acc = r; ms = r >= 128; mz = r == 0;
            end
            default: begin end
         endcase
      end
   end

   function automatic string tag_of(input logic [2:0] o, input logic l);
      if (!l) return "R2";
      case (o)
         3'd0: return "R3 R4";
         3'd1: return "R5";
         3'd2: return "R6";
         3'd3: return mn ? "R10 R11" : "R9 R11";
         3'd4: return "R7";
         3'd5: return "R8";
         default: return "R2";
      endcase
   endfunction

   task automatic compare(input string tag);
      logic [5:0] ef;
      ef = {ms, mz, mh, mpv, mn, mc};
      checks++;
      if (acc_o !== 8'(m_acc) || flags_o !== ef) begin
         errors++;
         $display("FAIL %s: acc=%h flags=%b expected acc=%h flags=%b",
                  tag, acc_o, flags_o, 8'(m_acc), ef);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(input logic [2:0] o, input logic [7:0] d, input logic l);
      string t;
      t = tag_of(o, l);
      op = o; imm = d; ld = l;
      @(posedge clk);
      @(negedge clk);
      compare(t);
   endtask

   task automatic set_acc(input int v, input int cv);
      step(3'd4, 8'((v - m_acc + 256) % 256), 1'b1);
      if (int'(mc) != cv) step(3'd1, 8'd0, 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: expired, actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      // R2: strobe low and unused selects leave state alone
      set_acc(8'h5A, 1);
      step(3'd0, 8'h11, 1'b0);
      step(3'd4, 8'hFF, 1'b0);
      step(3'd6, 8'h33, 1'b1);
      step(3'd7, 8'h44, 1'b1);

      // exhaustive sweep: every accumulator value, both carry states
      for (int v = 0; v < 256; v++) begin
         for (int cv = 0; cv < 2; cv++) begin
            for (int o = 0; o < 6; o++) begin
               set_acc(v, cv);
               step(3'(o), 8'((v * 37 + cv * 101 + o * 29 + 13) % 256), 1'b1);
            end
            // R10: decimal adjust after negation (subtract flag set)
            set_acc((256 - v) % 256, cv);
            step(3'd0, 8'd0, 1'b1);
            step(3'd3, 8'd0, 1'b1);
         end
      end

      // BCD sums followed by R9 correction
      for (int x = 0; x < 100; x += 7) begin
         for (int y = 0; y < 100; y += 11) begin
            set_acc((x / 10) * 16 + (x % 10), 0);
            step(3'd4, 8'((y / 10) * 16 + (y % 10)), 1'b1);
            step(3'd3, 8'd0, 1'b1);
         end
      end

      // R1: reset in the middle of operation
      set_acc(8'hC3, 1);
      rst_n = 1'b0;
      #1;
      rst_n = 1'b0;
      @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      @(negedge clk);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule